// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block keeps the interrupt enable byte and the timer and serial status flags of a small microcontroller core. Each of five sources (two external request lines, two timer overflows and one serial port) produces a request when its flag is set and its enable bit is on. A global enable gates all of them. A fixed priority picks one winning source index for the CPU's vector logic.

Timer flags are set by single-cycle overflow pulses. They clear themselves when the CPU acknowledges that timer's vector. The serial port has two flags, word received and word transmitted. Both feed one shared request line, and only a software write clears them. Every flag records its event whether or not the matching interrupt is enabled. The external flags are held outside this block and arrive as levels.

A byte-wide register port reads and writes the enable byte and the two status bytes. Reads are combinational. Writes take effect at the next clock edge.

Top module: `intr_flag_unit`

## Requirements
- R1: After reset all flags and enable bits are 0, every register address reads 0, no request is raised and the selected index is 0.
- R2: The enable byte is at address 0: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 7 global enable. Bits 5 and 6 read 0 whatever was written.
- R3: A timer 0 overflow pulse sets bit 5 and a timer 1 overflow pulse sets bit 7 of the timer status byte (address 1), at the next edge, even when the enable bits are 0.
- R4: A received-word pulse sets bit 0 and a transmitted-word pulse sets bit 1 of the serial status byte (address 2), at the next edge, even when the serial enable is 0.
- R5: Request line i (0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial) is high exactly when its flag is set, its enable bit is 1 and the global enable is 1. The serial flag is the OR of the received and transmitted flags. External flags are the input levels.
- R6: The selected index is the lowest-numbered active request line, with the valid output high. With no request, valid is low and the index is 0.
- R7: An acknowledge with index 1 clears the timer 0 flag and one with index 3 clears the timer 1 flag at the next edge.
- R8: An acknowledge never changes the serial flags or any flag it does not name.
- R9: A software write to address 1 or 2 loads the flag bits at their positions: 0 clears a flag and 1 sets it.
- R10: When a flag's set event coincides with a software clear or an acknowledge clear, the flag ends up set.
- R11: Bits of addresses 1 and 2 other than the flag positions, and all of address 3, read 0; writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext0_req_i | input | 1 | External 0 request flag level |
| ext1_req_i | input | 1 | External 1 request flag level |
| tmr0_ovf_i | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf_i | input | 1 | Timer 1 overflow pulse |
| ser_rx_i | input | 1 | Serial word received pulse |
| ser_tx_i | input | 1 | Serial word transmitted pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 enable, 1 timer status, 2 serial status |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Combinational read data |
| ack_i | input | 1 | Vector acknowledge strobe |
| ack_src_i | input | 3 | Index of the source being acknowledged |
| irq_o | output | 5 | Gated request per source |
| irq_valid_o | output | 1 | Some request is active |
| irq_src_o | output | 3 | Index of the winning request |

## Verification
Flag and enable updates caused by pulses, writes and acknowledges appear one edge later. The request lines, the selected index and the read data follow the stored state and the external levels in the same cycle. The bench drives inputs just after the falling edge and compares all outputs 1 ns later. That point lies before the next rising edge, so the comparison sees the state left by the previous edge. The bench model then advances its own state once for each rising edge. Directed corner cases cover coincident set and clear and acknowledges of non-timer sources. A seeded random run of mixed events follows them.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NUM_SRC = 5;
  localparam int SRC_W   = 3;
  localparam int DW      = 8;
  localparam int AW      = 2;

  localparam int SRC_EXT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_TMR1 = 3;
  localparam int SRC_SER  = 4;

  localparam int GLB_BIT = 7;
  localparam logic [DW-1:0] EN_MASK = 8'h9F;

  localparam logic [AW-1:0] ADDR_EN  = 2'd0;
  localparam logic [AW-1:0] ADDR_TMR = 2'd1;
  localparam logic [AW-1:0] ADDR_SER = 2'd2;

  localparam int NUM_TMR = 2;
  localparam int NUM_SERF = 2;

  // bit position of timer flag t in the timer status byte
  function automatic int tmr_bit(input int t);
    return (t == 0) ? 5 : 7;
  endfunction

  // source index acknowledged to clear timer t
  function automatic int tmr_src(input int t);
    return (t == 0) ? SRC_TMR0 : SRC_TMR1;
  endfunction

  // lowest index set in a request vector, 0 when none
  function automatic logic [SRC_W-1:0] first_set(input logic [NUM_SRC-1:0] v);
    logic [SRC_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = SRC_W'(i);
    end
    return r;
  endfunction

  // mask of all source positions below index s
  function automatic logic [NUM_SRC-1:0] below_mask(input logic [SRC_W-1:0] s);
    logic [NUM_SRC-1:0] m;
    for (int i = 0; i < NUM_SRC; i++) m[i] = (SRC_W'(i) < s);
    return m;
  endfunction
endpackage

// File: rtl/intr_en_reg.sv
module intr_en_reg
  import intr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      en_q,
  output logic [NUM_SRC-1:0] src_en,
  output logic               glb_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wdata & EN_MASK;
  end

  assign src_en = en_q[NUM_SRC-1:0];
  assign glb_en = en_q[GLB_BIT];

  // R2: bits outside the mask never become set
  a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~EN_MASK) == '0);

  // R2: a write is stored at the next edge
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en_q == ($past(wdata) & EN_MASK));
endmodule

// File: rtl/intr_flag_bank.sv
module intr_flag_bank
  import intr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TMR-1:0]  tmr_ovf,
  input  logic [NUM_SERF-1:0] ser_evt,
  input  logic                tmr_wr,
  input  logic [NUM_TMR-1:0]  tmr_wbits,
  input  logic                ser_wr,
  input  logic [NUM_SERF-1:0] ser_wbits,
  input  logic                ack,
  input  logic [SRC_W-1:0]    ack_src,
  output logic [NUM_TMR-1:0]  tmr_flag,
  output logic [NUM_SERF-1:0] ser_flag,
  output logic [DW-1:0]       tmr_rd,
  output logic [DW-1:0]       ser_rd
);
  logic [NUM_TMR-1:0] tmr_ack_hit;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    logic set_c, clr_c;
    assign tmr_ack_hit[t] = ack && (ack_src == SRC_W'(tmr_src(t)));
    assign set_c = tmr_ovf[t] || (tmr_wr && tmr_wbits[t]);
    assign clr_c = tmr_ack_hit[t] || (tmr_wr && !tmr_wbits[t]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tmr_flag[t] <= 1'b0;
      else if (set_c) tmr_flag[t] <= 1'b1;
      else if (clr_c) tmr_flag[t] <= 1'b0;
    end

    // R3/R10: an overflow always leaves the flag set
    a_r3_tmr_set: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf[t] |=> tmr_flag[t]);

    // R7: acknowledge of this timer clears its flag
    a_r7_tmr_ack_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_ack_hit[t] && !tmr_ovf[t] && !tmr_wr) |=> !tmr_flag[t]);

    // R8: an acknowledge for another source leaves the flag alone
    a_r8_tmr_other_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_ack_hit[t] && !tmr_ovf[t] && !tmr_wr) |=> $stable(tmr_flag[t]));
  end

  for (genvar s = 0; s < NUM_SERF; s++) begin : g_ser
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ser_flag[s] <= 1'b0;
      else if (ser_evt[s])                 ser_flag[s] <= 1'b1;
      else if (ser_wr)                     ser_flag[s] <= ser_wbits[s];
    end

    // R4: an event sets the flag at the next edge
    a_r4_ser_set: assert property (@(posedge clk) disable iff (!rst_n)
      ser_evt[s] |=> ser_flag[s]);

    // R8: only a software write can drop a serial flag
    a_r8_ser_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_flag[s] && !ser_wr) |=> ser_flag[s]);
  end

  always_comb begin
    tmr_rd = '0;
    for (int t = 0; t < NUM_TMR; t++) tmr_rd[tmr_bit(t)] = tmr_flag[t];
    ser_rd = '0;
    ser_rd[NUM_SERF-1:0] = ser_flag;
  end
endmodule

// File: rtl/intr_prio_sel.sv
module intr_prio_sel
  import intr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flag,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               glb_en,
  output logic [NUM_SRC-1:0] req,
  output logic               sel_valid,
  output logic [SRC_W-1:0]   sel_src
);
  assign req       = flag & src_en & {NUM_SRC{glb_en}};
  assign sel_valid = |req;
  assign sel_src   = first_set(req);

  // R5: global enable off means no request at all
  a_r5_glb_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> (req == '0));

  // R6: the winner is an active line
  a_r6_sel_active: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> req[sel_src]);

  // R6: no active line outranks the winner
  a_r6_sel_highest: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ((req & below_mask(sel_src)) == '0));

  // R6: idle index is zero
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (sel_src == '0));
endmodule

// File: rtl/intr_flag_unit.sv
module intr_flag_unit
  import intr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext0_req_i,
  input  logic               ext1_req_i,
  input  logic               tmr0_ovf_i,
  input  logic               tmr1_ovf_i,
  input  logic               ser_rx_i,
  input  logic               ser_tx_i,
  input  logic               reg_wr_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic               ack_i,
  input  logic [SRC_W-1:0]   ack_src_i,
  output logic [NUM_SRC-1:0] irq_o,
  output logic               irq_valid_o,
  output logic [SRC_W-1:0]   irq_src_o
);
  logic               en_wr, tmr_wr, ser_wr;
  logic [DW-1:0]      en_q, tmr_rd, ser_rd;
  logic [NUM_SRC-1:0] src_en, flag_all;
  logic               glb_en;
  logic [NUM_TMR-1:0] tmr_flag, tmr_wbits;
  logic [NUM_SERF-1:0] ser_flag;

  assign en_wr  = reg_wr_i && (reg_addr_i == ADDR_EN);
  assign tmr_wr = reg_wr_i && (reg_addr_i == ADDR_TMR);
  assign ser_wr = reg_wr_i && (reg_addr_i == ADDR_SER);

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_wb
    assign tmr_wbits[t] = reg_wdata_i[tmr_bit(t)];
  end

  intr_en_reg u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(en_wr), .wdata(reg_wdata_i),
    .en_q(en_q), .src_en(src_en), .glb_en(glb_en)
  );

  intr_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n),
    .tmr_ovf({tmr1_ovf_i, tmr0_ovf_i}),
    .ser_evt({ser_tx_i, ser_rx_i}),
    .tmr_wr(tmr_wr), .tmr_wbits(tmr_wbits),
    .ser_wr(ser_wr), .ser_wbits(reg_wdata_i[NUM_SERF-1:0]),
    .ack(ack_i), .ack_src(ack_src_i),
    .tmr_flag(tmr_flag), .ser_flag(ser_flag),
    .tmr_rd(tmr_rd), .ser_rd(ser_rd)
  );

  always_comb begin
    flag_all = '0;
    flag_all[SRC_EXT0] = ext0_req_i;
    flag_all[SRC_TMR0] = tmr_flag[0];
    flag_all[SRC_EXT1] = ext1_req_i;
    flag_all[SRC_TMR1] = tmr_flag[1];
    flag_all[SRC_SER]  = |ser_flag;
  end

  intr_prio_sel u_prio (
    .clk(clk), .rst_n(rst_n), .flag(flag_all), .src_en(src_en),
    .glb_en(glb_en), .req(irq_o), .sel_valid(irq_valid_o), .sel_src(irq_src_o)
  );

  always_comb begin
    case (reg_addr_i)
      ADDR_EN:  reg_rdata_o = en_q;
      ADDR_TMR: reg_rdata_o = tmr_rd;
      ADDR_SER: reg_rdata_o = ser_rd;
      default:  reg_rdata_o = '0;
    endcase
  end

  // R11: reserved address always reads zero
  a_r11_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == 2'd3) |-> (reg_rdata_o == '0));

  // R5: serial line follows the OR of its two flags under enables
  a_r5_ser_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[SRC_SER] == ((|ser_flag) && src_en[SRC_SER] && glb_en));
endmodule

// File: tb/sim_intr_flag_unit.sv
module sim_intr_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext0 = 0, ext1 = 0, ovf0 = 0, ovf1 = 0, rx = 0, tx = 0;
  logic       wr = 0, ack = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [2:0] asrc = 0;
  logic [7:0] rdata;
  logic [4:0] irq;
  logic       ivalid;
  logic [2:0] isrc;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [7:0] m_en = 0;
  logic m_tf0 = 0, m_tf1 = 0, m_ri = 0, m_ti = 0;

  always #2 clk = ~clk;

  intr_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .ext0_req_i(ext0), .ext1_req_i(ext1),
    .tmr0_ovf_i(ovf0), .tmr1_ovf_i(ovf1), .ser_rx_i(rx), .ser_tx_i(tx),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_i(ack), .ack_src_i(asrc), .irq_o(irq), .irq_valid_o(ivalid), .irq_src_o(isrc)
  );

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_en;
      2'd1: return {m_tf1, 1'b0, m_tf0, 5'b0};
      2'd2: return {6'b0, m_ti, m_ri};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [4:0] exp_irq();
    logic [4:0] f;
    f = {m_ri | m_ti, m_tf1, ext1, m_tf0, ext0};
    return m_en[7] ? (f & m_en[4:0]) : 5'b0;
  endfunction

  function automatic logic [2:0] exp_src();
    logic [4:0] r;
    r = exp_irq();
    for (int i = 0; i < 5; i++) if (r[i]) return 3'(i);
    return 3'd0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    string rtag;
    rtag = (addr == 0) ? "R2" : (addr == 1) ? "R3/R9" : (addr == 2) ? "R4/R9" : "R11";
    chk({tag, " ", rtag, " rdata"}, rdata, exp_rd(addr));
    chk({tag, " R5 irq"}, irq, exp_irq());
    chk({tag, " R6 valid"}, ivalid, |exp_irq());
    chk({tag, " R6 src"}, isrc, exp_src());
  endtask

  task automatic model_edge();
    logic s, c;
    if (wr && addr == 0) m_en = wdata & 8'h9F;
    s = ovf0 | (wr && addr == 1 && wdata[5]);
    c = (ack && asrc == 1) | (wr && addr == 1 && !wdata[5]);
    m_tf0 = s ? 1'b1 : c ? 1'b0 : m_tf0;
    s = ovf1 | (wr && addr == 1 && wdata[7]);
    c = (ack && asrc == 3) | (wr && addr == 1 && !wdata[7]);
    m_tf1 = s ? 1'b1 : c ? 1'b0 : m_tf1;
    s = rx | (wr && addr == 2 && wdata[0]);
    c = wr && addr == 2 && !wdata[0];
    m_ri = s ? 1'b1 : c ? 1'b0 : m_ri;
    s = tx | (wr && addr == 2 && wdata[1]);
    c = wr && addr == 2 && !wdata[1];
    m_ti = s ? 1'b1 : c ? 1'b0 : m_ti;
  endtask

  // inputs are set just after negedge; compare, then take one edge
  task automatic step(input string tag);
    #1;
    check_all(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    {wr, ack, ovf0, ovf1, rx, tx} = '0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d, input string tag);
    wr = 1; addr = a; wdata = d;
    step(tag);
  endtask

  task automatic peek(input logic [1:0] a, input string tag);
    addr = a;
    step(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state on every address
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      chk("R1 reset rdata", rdata, 0);
    end
    chk("R1 reset irq", irq, 0);
    chk("R1 reset src", isrc, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: enable bits 5,6 dropped
    wreg(2'd0, 8'hFF, "R2 write");
    peek(2'd0, "R2 readback");
    chk("R2 en value", exp_rd(0), 8'h9F);
    wreg(2'd0, 8'h00, "R2 clear");

    // R3/R4: flags set with everything disabled
    ovf0 = 1; ovf1 = 1; addr = 1; step("R3 ovf");
    peek(2'd1, "R3 flags");
    chk("R3 tmr byte", rdata, 8'hA0);
    rx = 1; addr = 2; step("R4 rx");
    peek(2'd2, "R4 ri");
    chk("R4 ser byte", rdata, 8'h01);
    tx = 1; step("R4 tx");
    peek(2'd2, "R4 both");
    chk("R4 ser byte both", rdata, 8'h03);

    // R5/R6: enable all with externals active, priority ordering
    ext0 = 1; ext1 = 1;
    wreg(2'd0, 8'h9F, "R5 enable");
    peek(2'd0, "R6 ext0 wins");
    chk("R6 src ext0", isrc, 0);
    ext0 = 0; peek(2'd0, "R6 tmr0 wins");
    chk("R6 src tmr0", isrc, 1);
    wreg(2'd0, 8'h1F, "R5 global off");
    peek(2'd0, "R5 no global");
    chk("R5 global gates", irq, 0);
    wreg(2'd0, 8'h90, "R5 serial only");
    peek(2'd0, "R5 serial line");
    chk("R5 serial irq", irq, 5'h10);

    // R8: acks of ext/serial leave flags; R7: timer ack clears
    ack = 1; asrc = 4; addr = 2; step("R8 ser ack");
    peek(2'd2, "R8 ser kept");
    chk("R8 ser byte", rdata, 8'h03);
    ack = 1; asrc = 0; addr = 1; step("R8 ext ack");
    peek(2'd1, "R8 tmr kept");
    chk("R8 tmr byte", rdata, 8'hA0);
    ack = 1; asrc = 1; step("R7 ack tmr0");
    peek(2'd1, "R7 tf0 clr");
    chk("R7 tmr byte", rdata, 8'h80);
    // R10: overflow and ack together
    ack = 1; asrc = 3; ovf1 = 1; step("R10 ack+ovf");
    peek(2'd1, "R10 tf1 kept");
    chk("R10 tmr byte", rdata, 8'h80);
    // R10: software clear and rx together
    wr = 1; addr = 2; wdata = 8'h00; rx = 1; step("R10 wr+rx");
    peek(2'd2, "R10 ri kept");
    chk("R10 ser byte", rdata, 8'h01);
    // R9: software clear and set; R11: other bits ignored
    wreg(2'd2, 8'hFC, "R9 clear ser");
    peek(2'd2, "R9 ser cleared");
    chk("R9/R11 ser byte", rdata, 8'h00);
    wreg(2'd1, 8'h7F, "R9 set tf0");
    peek(2'd1, "R9 tf0 set");
    chk("R9/R11 tmr byte", rdata, 8'h20);
    wreg(2'd3, 8'hFF, "R11 rsvd write");
    peek(2'd3, "R11 rsvd read");
    chk("R11 rsvd zero", rdata, 0);
    ext1 = 0;

    // random mix
    for (int n = 0; n < 4000; n++) begin
      ext0 = ($urandom % 3) == 0;
      ext1 = ($urandom % 3) == 0;
      ovf0 = ($urandom % 8) == 0;
      ovf1 = ($urandom % 8) == 0;
      rx   = ($urandom % 9) == 0;
      tx   = ($urandom % 9) == 0;
      wr   = ($urandom % 6) == 0;
      ack  = ($urandom % 4) == 0;
      asrc = 3'($urandom % 8);
      addr = 2'($urandom % 4);
      wdata = 8'($urandom);
      if (wr && addr == 0) wdata[7] = ($urandom % 4) != 0;
      step("rand");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule